// File: doc/BRIEF.md
# Floating-Point Issue Stage with Reservation Stations and Rename Buffer

This block is the issue side of an out-of-order floating-point unit. Every accepted instruction claims one entry of a circular rename buffer for its destination register, and that entry's index (its color) becomes the tag under which the result will later be broadcast. The instruction also claims a free reservation station of its unit class: add/subtract, multiply or divide. Each of its two source operands is captured either as a value or as the color of the producer that has not yet delivered.

Result broadcasts carry a color and a value. A broadcast completes the matching rename entry and, in the same cycle, fills every station operand that was waiting on that color. A station is ready once both operands hold values. For each class, the lowest-index ready station is presented to the functional unit, and that station is released when the unit takes it. Issue stalls while the rename buffer is full or while the instruction's class has no free station. An external retire pulse releases rename entries in allocation order.

Top module: `fprs_issue`

## Requirements
- R1: Opcode encodings are 0 add, 1 sub, 2 mul and 3 div. Add and sub use stations 0 to 2, mul uses stations 3 to 4 and div uses station 5. Bit i of `rs_ready` belongs to station i. Bit 0 of the per-class port arrays is add/sub, bit 1 is mul and bit 2 is div.
- R2: An accepted issue loads the lowest-index free station of its class. `iss_stall` is high whenever every station of that class is busy.
- R3: Each accepted issue allocates the rename entry at the circular tail and reports its index on `iss_color` in the same cycle. Repeated writes to one register receive distinct colors.
- R4: `iss_stall` is high while all 8 rename entries are busy, even when stations are free.
- R5: A source operand is resolved from the newest busy rename entry for its register. If that entry is still pending, the operand holds its color. If that entry has completed, the operand holds the entry's value. If no such entry exists, the operand holds the register-file value supplied with the issue.
- R6: A broadcast to a busy rename entry stores the value and marks the entry complete, as seen on the head outputs one cycle later.
- R7: A broadcast replaces the matching color in every waiting operand of every station in the same cycle.
- R8: `rs_ready` is set for a station exactly when it is busy and both of its operands hold values.
- R9: A source whose pending producer is broadcast in the same cycle as the issue is captured as the broadcast value.
- R10: `fu_valid` for a class presents the lowest-index ready station's op, color and operands. `fu_take` releases that station at the next edge.
- R11: After reset, all stations and rename entries are free. A retire pulse frees the oldest rename entry, and allocation wraps circularly into the freed entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 2 | Opcode (0 add, 1 sub, 2 mul, 3 div) |
| iss_dst | input | AW | Destination register |
| iss_src1 | input | AW | First source register |
| iss_src2 | input | AW | Second source register |
| iss_src1_val | input | DW | Register-file value of first source |
| iss_src2_val | input | DW | Register-file value of second source |
| iss_stall | output | 1 | Issue cannot be accepted this cycle |
| iss_color | output | CW | Color allocated to the destination |
| bc_valid | input | 1 | Result broadcast valid |
| bc_color | input | CW | Color of the broadcast result |
| bc_value | input | DW | Broadcast value |
| retire | input | 1 | Free the oldest rename entry |
| rs_ready | output | NST | Per-station ready flags |
| fu_take | input | 3 | Per-class take of the presented station |
| fu_valid | output | 3 | Per-class ready station present |
| fu_op | output | 3x2 | Per-class presented opcode |
| fu_color | output | 3xCW | Per-class presented destination color |
| fu_a | output | 3xDW | Per-class first operand value |
| fu_b | output | 3xDW | Per-class second operand value |
| rb_head_busy | output | 1 | Oldest rename entry is occupied |
| rb_head_done | output | 1 | Oldest rename entry holds its result |
| rb_head_reg | output | AW | Register of the oldest rename entry |
| rb_head_value | output | DW | Value of the oldest rename entry |

## Verification
`iss_stall` and `iss_color` are combinational and are due in the cycle of the request, so the bench reads them one nanosecond after driving, before the edge. Station state, `rs_ready`, the per-class presentation and the head outputs change at the edge that takes an issue, broadcast, take or retire. The bench drives every stimulus on a falling edge and checks the result at the next falling edge, which is exactly one register stage later. The same-cycle broadcast case is checked by holding the broadcast and the issue together across a single rising edge.

// File: rtl/fprs_pkg.sv
package fprs_pkg;

  localparam int unsigned NCLS = 3;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } fp_op_e;

  // unit class of an opcode: 0 add/sub, 1 multiply, 2 divide
  function automatic logic [1:0] op_class(input fp_op_e op);
    case (op)
      OP_MUL:  return 2'd1;
      OP_DIV:  return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/fprs_pick.sv
module fprs_pick #(
  parameter int unsigned N  = 3,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/fprs_station.sv
module fprs_station
  import fprs_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  fp_op_e        ld_op,
  input  logic [CW-1:0] ld_color,
  input  logic          ld_a_rdy,
  input  logic [DW-1:0] ld_a,
  input  logic          ld_b_rdy,
  input  logic [DW-1:0] ld_b,
  input  logic          take,
  input  logic          bc_valid,
  input  logic [CW-1:0] bc_color,
  input  logic [DW-1:0] bc_value,
  output logic          busy,
  output logic          ready,
  output fp_op_e        op,
  output logic [CW-1:0] color,
  output logic [DW-1:0] a_d,
  output logic [DW-1:0] b_d
);
  logic a_rdy, b_rdy;
  logic a_fill, b_fill;

  // operand waiting on the broadcast color picks the value up
  assign a_fill = busy && !a_rdy && bc_valid && (a_d[CW-1:0] == bc_color);
  assign b_fill = busy && !b_rdy && bc_valid && (b_d[CW-1:0] == bc_color);
  assign ready  = busy && a_rdy && b_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      op    <= OP_ADD;
      color <= '0;
      a_rdy <= 1'b0;
      b_rdy <= 1'b0;
      a_d   <= '0;
      b_d   <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      op    <= ld_op;
      color <= ld_color;
      a_rdy <= ld_a_rdy;
      a_d   <= ld_a;
      b_rdy <= ld_b_rdy;
      b_d   <= ld_b;
    end else begin
      if (take) busy <= 1'b0;
      if (a_fill) begin
        a_rdy <= 1'b1;
        a_d   <= bc_value;
      end
      if (b_fill) begin
        b_rdy <= 1'b1;
        b_d   <= bc_value;
      end
    end
  end

  p_load_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
  p_take_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ready);
  p_take_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take && !load |=> !busy);
  p_ready_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !take |=> ready);
  p_bcast_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    a_fill && !take |=> a_rdy && (a_d == $past(bc_value)));
endmodule

// File: rtl/fprs_rename.sv
module fprs_rename #(
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 3,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic [AW-1:0] alloc_reg,
  input  logic          retire,
  input  logic          bc_valid,
  input  logic [CW-1:0] bc_color,
  input  logic [DW-1:0] bc_value,
  input  logic [AW-1:0] q_reg    [2],
  input  logic [DW-1:0] q_rf_val [2],
  output logic          q_rdy    [2],
  output logic [DW-1:0] q_data   [2],
  output logic          full,
  output logic [CW-1:0] tail,
  output logic          head_busy,
  output logic          head_done,
  output logic [AW-1:0] head_reg,
  output logic [DW-1:0] head_value
);
  logic          busy [DEPTH];
  logic          done [DEPTH];
  logic [AW-1:0] areg [DEPTH];
  logic [DW-1:0] val  [DEPTH];
  logic [CW-1:0] head;
  logic [CW:0]   count;
  logic          ret_eff;

  function automatic logic [CW-1:0] ring(input logic [CW-1:0] base, input int k);
    return base + CW'(k);
  endfunction

  assign full       = (count == (CW+1)'(DEPTH));
  assign ret_eff    = retire && busy[head];
  assign head_busy  = busy[head];
  assign head_done  = done[head];
  assign head_reg   = areg[head];
  assign head_value = val[head];

  // newest busy entry wins: walk from oldest to youngest
  for (genvar p = 0; p < 2; p++) begin : g_look
    logic          hit;
    logic [CW-1:0] sel;
    always_comb begin
      hit = 1'b0;
      sel = '0;
      for (int k = 0; k < DEPTH; k++) begin
        if (busy[ring(head, k)] && areg[ring(head, k)] == q_reg[p]) begin
          hit = 1'b1;
          sel = ring(head, k);
        end
      end
      if (!hit) begin
        q_rdy[p]  = 1'b1;
        q_data[p] = q_rf_val[p];
      end else if (done[sel]) begin
        q_rdy[p]  = 1'b1;
        q_data[p] = val[sel];
      end else if (bc_valid && bc_color == sel) begin
        q_rdy[p]  = 1'b1;
        q_data[p] = bc_value;
      end else begin
        q_rdy[p]  = 1'b0;
        q_data[p] = DW'(sel);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        busy[i] <= 1'b0;
        done[i] <= 1'b0;
        areg[i] <= '0;
        val[i]  <= '0;
      end
    end else begin
      if (alloc) begin
        busy[tail] <= 1'b1;
        done[tail] <= 1'b0;
        areg[tail] <= alloc_reg;
        tail       <= tail + 1'b1;
      end
      if (bc_valid && busy[bc_color]) begin
        done[bc_color] <= 1'b1;
        val[bc_color]  <= bc_value;
      end
      if (ret_eff) begin
        busy[head] <= 1'b0;
        head       <= head + 1'b1;
      end
      count <= count + (CW+1)'(alloc) - (CW+1)'(ret_eff);
    end
  end

  p_no_alloc_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !full);
  p_bcast_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid && busy[bc_color] && !(ret_eff && head == bc_color)
    |=> done[$past(bc_color)] && val[$past(bc_color)] == $past(bc_value));
  p_retire_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ret_eff && !alloc |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/fprs_issue.sv
module fprs_issue
  import fprs_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned NAREG = 8,
  parameter int unsigned RBD   = 8,
  parameter int unsigned NADD  = 3,
  parameter int unsigned NMUL  = 2,
  parameter int unsigned NDIV  = 1,
  localparam int unsigned AW   = $clog2(NAREG),
  localparam int unsigned CW   = $clog2(RBD),
  localparam int unsigned NST  = NADD + NMUL + NDIV,
  localparam int unsigned SIW  = $clog2(NST)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      iss_valid,
  input  logic [1:0]                iss_op,
  input  logic [AW-1:0]             iss_dst,
  input  logic [AW-1:0]             iss_src1,
  input  logic [AW-1:0]             iss_src2,
  input  logic [DW-1:0]             iss_src1_val,
  input  logic [DW-1:0]             iss_src2_val,
  output logic                      iss_stall,
  output logic [CW-1:0]             iss_color,
  input  logic                      bc_valid,
  input  logic [CW-1:0]             bc_color,
  input  logic [DW-1:0]             bc_value,
  input  logic                      retire,
  output logic [NST-1:0]            rs_ready,
  input  logic [NCLS-1:0]           fu_take,
  output logic [NCLS-1:0]           fu_valid,
  output logic [NCLS-1:0][1:0]      fu_op,
  output logic [NCLS-1:0][CW-1:0]   fu_color,
  output logic [NCLS-1:0][DW-1:0]   fu_a,
  output logic [NCLS-1:0][DW-1:0]   fu_b,
  output logic                      rb_head_busy,
  output logic                      rb_head_done,
  output logic [AW-1:0]             rb_head_reg,
  output logic [DW-1:0]             rb_head_value
);
  function automatic int cls_base(input int c);
    return (c == 0) ? 0 : (c == 1) ? int'(NADD) : int'(NADD + NMUL);
  endfunction
  function automatic int cls_size(input int c);
    return (c == 0) ? int'(NADD) : (c == 1) ? int'(NMUL) : int'(NDIV);
  endfunction
  function automatic logic [1:0] st_class(input int s);
    return (s < int'(NADD)) ? 2'd0 : (s < int'(NADD + NMUL)) ? 2'd1 : 2'd2;
  endfunction

  fp_op_e        op_in;
  logic [1:0]    iss_cls;
  logic          have_free;
  logic [SIW-1:0] free_idx;
  logic          rb_full;
  logic          accept;
  logic [NST-1:0] st_load;
  logic [NST-1:0] st_take;
  logic [NST-1:0] st_busy;
  fp_op_e        st_op    [NST];
  logic [CW-1:0] st_color [NST];
  logic [DW-1:0] st_a     [NST];
  logic [DW-1:0] st_b     [NST];
  logic [AW-1:0] q_reg    [2];
  logic [DW-1:0] q_rf_val [2];
  logic          q_rdy    [2];
  logic [DW-1:0] q_data   [2];

  assign op_in     = fp_op_e'(iss_op);
  assign iss_cls   = op_class(op_in);
  assign iss_stall = rb_full || !have_free;
  assign accept    = iss_valid && !iss_stall;

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int s = 0; s < NST; s++) begin
      if (st_class(s) == iss_cls && !st_busy[s] && !have_free) begin
        have_free = 1'b1;
        free_idx  = SIW'(s);
      end
    end
    for (int s = 0; s < NST; s++) st_load[s] = accept && (free_idx == SIW'(s));
  end

  assign q_reg[0]    = iss_src1;
  assign q_reg[1]    = iss_src2;
  assign q_rf_val[0] = iss_src1_val;
  assign q_rf_val[1] = iss_src2_val;

  fprs_rename #(.DW(DW), .AW(AW), .DEPTH(RBD)) u_rename (
    .clk, .rst_n,
    .alloc(accept), .alloc_reg(iss_dst), .retire,
    .bc_valid, .bc_color, .bc_value,
    .q_reg, .q_rf_val, .q_rdy, .q_data,
    .full(rb_full), .tail(iss_color),
    .head_busy(rb_head_busy), .head_done(rb_head_done),
    .head_reg(rb_head_reg), .head_value(rb_head_value)
  );

  for (genvar s = 0; s < NST; s++) begin : g_st
    fprs_station #(.DW(DW), .CW(CW)) u_st (
      .clk, .rst_n,
      .load(st_load[s]), .ld_op(op_in), .ld_color(iss_color),
      .ld_a_rdy(q_rdy[0]), .ld_a(q_data[0]),
      .ld_b_rdy(q_rdy[1]), .ld_b(q_data[1]),
      .take(st_take[s]),
      .bc_valid, .bc_color, .bc_value,
      .busy(st_busy[s]), .ready(rs_ready[s]), .op(st_op[s]),
      .color(st_color[s]), .a_d(st_a[s]), .b_d(st_b[s])
    );
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    localparam int BASE = cls_base(c);
    localparam int SIZE = cls_size(c);
    localparam int IW   = (SIZE > 1) ? $clog2(SIZE) : 1;
    logic           found;
    logic [IW-1:0]  idx;
    logic [SIW-1:0] sel;
    logic [SIZE-1:0] tk;

    fprs_pick #(.N(SIZE), .IW(IW)) u_pick (
      .req(rs_ready[BASE +: SIZE]), .found, .idx
    );

    assign sel         = SIW'(BASE) + SIW'(idx);
    assign fu_valid[c] = found;
    assign fu_op[c]    = st_op[sel];
    assign fu_color[c] = st_color[sel];
    assign fu_a[c]     = st_a[sel];
    assign fu_b[c]     = st_b[sel];

    always_comb begin
      for (int i = 0; i < SIZE; i++) tk[i] = fu_take[c] && found && (idx == IW'(i));
    end
    assign st_take[BASE +: SIZE] = tk;
  end

  p_one_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(st_load));
  p_take_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st_take) <= NCLS);
  p_accept_alloc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> iss_color == $past(iss_color) + 1'b1);
endmodule

// File: tb/fprs_issue_tb.sv
`timescale 1ns/1ps
module fprs_issue_tb;
  import fprs_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic [1:0] iss_op = 2'd0;
  logic [2:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
  logic [31:0] iss_src1_val = '0, iss_src2_val = '0;
  logic iss_stall;
  logic [2:0] iss_color;
  logic bc_valid = 1'b0;
  logic [2:0] bc_color = '0;
  logic [31:0] bc_value = '0;
  logic retire = 1'b0;
  logic [5:0] rs_ready;
  logic [2:0] fu_take = '0;
  logic [2:0] fu_valid;
  logic [2:0][1:0] fu_op;
  logic [2:0][2:0] fu_color;
  logic [2:0][31:0] fu_a, fu_b;
  logic rb_head_busy, rb_head_done;
  logic [2:0] rb_head_reg;
  logic [31:0] rb_head_value;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  fprs_issue u_dut (
    .clk, .rst_n, .iss_valid, .iss_op, .iss_dst, .iss_src1, .iss_src2,
    .iss_src1_val, .iss_src2_val, .iss_stall, .iss_color,
    .bc_valid, .bc_color, .bc_value, .retire, .rs_ready,
    .fu_take, .fu_valid, .fu_op, .fu_color, .fu_a, .fu_b,
    .rb_head_busy, .rb_head_done, .rb_head_reg, .rb_head_value
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // all tasks start and end on a falling edge
  task automatic do_issue(input logic [1:0] op, input int dst, input int s1, input int s2,
                          input logic [31:0] v1, input logic [31:0] v2,
                          input int exp_c, input string tag);
    iss_valid = 1'b1; iss_op = op; iss_dst = 3'(dst);
    iss_src1 = 3'(s1); iss_src2 = 3'(s2); iss_src1_val = v1; iss_src2_val = v2;
    #1;
    chk({tag, " stall"}, iss_stall, 0);
    chk({tag, " color"}, iss_color, exp_c);
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic probe_stall(input logic [1:0] op, input string tag);
    iss_valid = 1'b1; iss_op = op;
    #1;
    chk(tag, iss_stall, 1);
    iss_valid = 1'b0;
  endtask

  task automatic do_bcast(input int c, input logic [31:0] v);
    bc_valid = 1'b1; bc_color = 3'(c); bc_value = v;
    @(negedge clk);
    bc_valid = 1'b0;
  endtask

  task automatic do_take(input int c);
    fu_take[c] = 1'b1;
    @(negedge clk);
    fu_take = '0;
  endtask

  task automatic do_retire();
    retire = 1'b1;
    @(negedge clk);
    retire = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 reset rs_ready", rs_ready, 0);
    chk("R11 reset fu_valid", fu_valid, 0);
    chk("R11 reset head_busy", rb_head_busy, 0);
    chk("R11 reset stall", iss_stall, 0);
  endtask

  // registers: f1=1 f2=2 f3=80 f4=4 f5=2 (values given with each issue)
  task automatic t_mixed_issue();
    do_reset();
    do_issue(2'd3, 1, 3, 4, 80, 4, 0, "R3 div");
    do_issue(2'd2, 2, 3, 5, 80, 2, 1, "R3 mul");
    do_issue(2'd0, 3, 1, 2, 0, 0, 2, "R3 add");
    do_issue(2'd0, 3, 4, 2, 4, 0, 3, "R3 add same dst");
    do_issue(2'd2, 4, 2, 4, 0, 4, 4, "R3 mul2");
    do_issue(2'd1, 5, 4, 5, 4, 2, 5, "R3 sub");
    chk("R8 R1 only div and first mul ready", rs_ready, 6'b101000);
    chk("R10 class valid", fu_valid, 3'b110);
    chk("R5 div color", fu_color[2], 0);
    chk("R5 div a", fu_a[2], 80);
    chk("R5 div b", fu_b[2], 4);
    chk("R10 mul color", fu_color[1], 1);
    probe_stall(2'd2, "R2 mul stations full");
    probe_stall(2'd1, "R2 add stations full");
    probe_stall(2'd3, "R2 div station full");
    chk("R11 head busy", rb_head_busy, 1);
    chk("R6 head pending", rb_head_done, 0);
    chk("R11 head reg", rb_head_reg, 1);
    do_bcast(1, 160);
    chk("R7 fill across stations", rs_ready, 6'b111010);
    do_bcast(0, 20);
    chk("R7 second fill", rs_ready, 6'b111011);
    chk("R6 head done", rb_head_done, 1);
    chk("R6 head value", rb_head_value, 20);
    chk("R10 add pick color", fu_color[0], 2);
    chk("R10 add pick a", fu_a[0], 20);
    chk("R10 add pick b", fu_b[0], 160);
    chk("R1 add op", fu_op[0], 0);
    do_take(0);
    chk("R10 station freed", rs_ready, 6'b111010);
    chk("R10 next add color", fu_color[0], 3);
    chk("R10 next add a", fu_a[0], 4);
    do_take(0);
    chk("R8 sub waits", rs_ready, 6'b111000);
    do_bcast(4, 640);
    chk("R7 sub filled", rs_ready, 6'b111100);
    chk("R1 sub op", fu_op[0], 1);
    chk("R5 sub a", fu_a[0], 640);
    chk("R5 sub b", fu_b[0], 2);
    chk("R5 sub color", fu_color[0], 5);
    do_take(1);
    chk("R10 mul2 color", fu_color[1], 4);
    chk("R10 mul2 a", fu_a[1], 160);
    chk("R10 mul2 b", fu_b[1], 4);
  endtask

  task automatic t_rename_ring();
    do_reset();
    for (int i = 0; i < 8; i++) begin
      do_issue(2'd0, 2, 0, 1, 1, 2, i, "R3 repeated dst");
      do_take(0);
    end
    chk("R4 stations idle", rs_ready, 0);
    probe_stall(2'd0, "R4 rename full stall");
    do_bcast(7, 99);
    do_bcast(0, 11);
    chk("R6 head value", rb_head_value, 11);
    do_retire();
    chk("R11 head advanced", rb_head_done, 0);
    chk("R11 head still busy", rb_head_busy, 1);
    do_issue(2'd0, 3, 2, 0, 5, 1, 0, "R11 wrap color");
    chk("R5 done entry ready", rs_ready, 6'b000001);
    chk("R5 newest done value", fu_a[0], 99);
    chk("R5 register file value", fu_b[0], 1);
    do_take(0);
    do_retire();
    bc_valid = 1'b1; bc_color = 3'd0; bc_value = 32'd7;
    do_issue(2'd0, 4, 3, 3, 5, 5, 1, "R9 issue with bcast");
    bc_valid = 1'b0;
    chk("R9 ready", rs_ready, 6'b000001);
    chk("R9 a bypass", fu_a[0], 7);
    chk("R9 b bypass", fu_b[0], 7);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hang expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_mixed_issue();
    t_rename_ring();
    summary();
    $finish;
  end
endmodule